// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects clocked logic to an external asynchronous static RAM of 262,144 sixteen-bit words. The user side has a simple handshake. When `ready` is high, a one-cycle `req` with an 18-bit address, a write flag, a two-bit lane mask and 16 bits of write data starts one access. The controller then holds every memory-side signal steady until the access is done. It returns `ready` high with read data in `rdata`. The memory side has active-low chip select, output enable, write strobe and two byte-lane strobes. The bidirectional data bus is split into an outgoing value, a drive enable and an incoming value, so the tristate buffer lives in the pad ring.

Each analog timing limit of the memory is turned into a whole number of clock cycles. The conversion rounds the limit in nanoseconds up over the clock period, with a floor of one cycle. `CLK_NS` sets the clock period and `GRADE_NS` picks the 70 ns or the 85 ns speed set. Output enable stays high for every write. After any read, the controller waits out the memory's output-disable time before it drives the bus. Between accesses the memory is deselected into standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `ready` is high the memory is in standby: chip select, output enable, write strobe and both lane strobes are high (inactive) and `sram_dq_oe` is low. This is also the state after reset.
- R2: A request is taken only on a clock edge where `req` and `ready` are both high, and `ready` is low in the following cycle. For as long as chip select stays low, the address, the lane strobes and the outgoing data do not change.
- R3: A read holds chip select low, output enable low and write strobe high for exactly the read-cycle count. Lane mask bit 0 drives the lower strobe (data bits 7:0) low and bit 1 drives the upper strobe (bits 15:8) low.
- R4: Read data is sampled from the bus in the last cycle of the read count and held in `rdata` until the next read ends. A lane whose mask bit is 0 reads as zero.
- R5: A write keeps output enable high throughout and holds the write strobe low for exactly the write-pulse count. Only lanes whose mask bit is 1 are strobed, so a mask of 00 changes no memory word.
- R6: Write data is driven (`sram_dq_oe` high) for the whole write-strobe pulse and at least one cycle after it ends, so setup before the strobe's rising edge is at least 30 ns. Chip select stays low for at least the write-cycle time.
- R7: `sram_dq_oe` rises no sooner than the output-disable count after output enable last went high.
- R8: Cycle counts are ceil(limit / `CLK_NS`) with a minimum of 1. At 10 ns with the 70 ns set this gives: read 7 cycles, write pulse 6 (max of pulse width 55 ns and data setup 30 ns), write cycle 7, turnaround 3.
- R9: After each access `ready` returns high with chip select high, even when the user immediately has a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken while `ready` is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_lanes | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Idle and able to take a request |
| rdata | output | 16 | Data of the last completed read |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_lb_n | output | 1 | Lower lane strobe, active low |
| sram_ub_n | output | 1 | Upper lane strobe, active low |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data seen on the memory bus |

## Verification
The hardest case to reach is a write that follows a read on the next possible cycle. Only then does the bus-turnaround guard decide when the drivers turn on. The bench issues read-then-write pairs both as directed cases and often in the random mix. Its memory model timestamps the rising edge of output enable and each rising edge of the drive enable, and flags any gap below the memory's 25 ns release time. The same model returns a poison pattern until 68 ns after the address or controls change. It also checks strobe width and data setup in nanoseconds, so a sample or a strobe edge that is one cycle early shows up as a mismatch.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    localparam int ADDR_W    = 18;
    localparam int DATA_W    = 16;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int CNT_W     = 8;

    // Timing limits of one speed set, in nanoseconds
    typedef struct packed {
        int rd_ns;   // read cycle / address access
        int wp_ns;   // minimum write strobe pulse
        int ds_ns;   // data setup before strobe rise
        int wc_ns;   // minimum write cycle
        int ohz_ns;  // output release after output enable rises
    } limits_t;

    // Request fields held for the whole access
    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic [NUM_LANES-1:0] lanes;
        logic [DATA_W-1:0]    wdata;
    } xfer_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WWAIT  = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WREC   = 3'd4
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // ceil(ns / clk_ns), at least one cycle
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic limits_t grade_limits(input int grade_ns);
        limits_t l;
        if (grade_ns >= 85) begin
            l.rd_ns = 85; l.wp_ns = 55; l.ds_ns = 35; l.wc_ns = 85; l.ohz_ns = 35;
        end else begin
            l.rd_ns = 70; l.wp_ns = 55; l.ds_ns = 30; l.wc_ns = 70; l.ohz_ns = 25;
        end
        return l;
    endfunction

endpackage

// File: rtl/sram_req_hold.sv
`timescale 1ns/1ps
module sram_req_hold
    import sram_lane_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  xfer_t din,
    output xfer_t dout
);

    xfer_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= din;
        end
    end

    assign dout = held_q;

endmodule

// File: rtl/sram_phase_ctr.sv
`timescale 1ns/1ps
module sram_phase_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_turn_guard.sv
`timescale 1ns/1ps
module sram_turn_guard #(
    parameter int W      = 8,
    parameter int TA_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic clear
);

    localparam logic [W-1:0] TA_VAL = W'(TA_CYC);

    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (arm) begin
            left_q <= TA_VAL;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign clear = (left_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int RD_CYC  = 7,
    parameter int WP_CYC  = 6,
    parameter int REC_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_wr,
    input  logic             phase_last,
    input  logic             guard_clear,
    output seq_state_t       state,
    output logic             accept,
    output logic             phase_load,
    output logic [CNT_W-1:0] phase_val,
    output logic             guard_arm,
    output logic             capture
);

    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

    seq_state_t state_q, state_d;

    always_comb begin
        state_d    = state_q;
        phase_load = 1'b0;
        phase_val  = '0;
        guard_arm  = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (req_wr) begin
                        state_d = ST_WWAIT;
                    end else begin
                        state_d    = ST_READ;
                        phase_load = 1'b1;
                        phase_val  = RD_LAST;
                    end
                end
            end
            ST_READ: begin
                if (phase_last) begin
                    capture   = 1'b1;
                    guard_arm = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_WWAIT: begin
                if (guard_clear) begin
                    state_d    = ST_WPULSE;
                    phase_load = 1'b1;
                    phase_val  = WP_LAST;
                end
            end
            ST_WPULSE: begin
                if (phase_last) begin
                    state_d    = ST_WREC;
                    phase_load = 1'b1;
                    phase_val  = REC_LAST;
                end
            end
            ST_WREC: begin
                if (phase_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state  = state_q;
    assign accept = req && (state_q == ST_IDLE);

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int GRADE_NS = 70
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NUM_LANES-1:0] req_lanes,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam limits_t LIM = grade_limits(GRADE_NS);
    localparam int RD_CYC  = ns_to_cyc(LIM.rd_ns, CLK_NS);
    localparam int WP_CYC  = ns_to_cyc(max2(LIM.wp_ns, LIM.ds_ns), CLK_NS);
    localparam int WC_CYC  = ns_to_cyc(LIM.wc_ns, CLK_NS);
    localparam int REC_CYC = max2(1, WC_CYC - WP_CYC);
    localparam int TA_CYC  = ns_to_cyc(LIM.ohz_ns, CLK_NS);

    seq_state_t           state;
    logic                 accept;
    logic                 phase_load;
    logic [CNT_W-1:0]     phase_val;
    logic                 phase_last;
    logic                 guard_arm;
    logic                 guard_clear;
    logic                 capture;
    xfer_t                new_xfer;
    xfer_t                cur_xfer;
    logic                 active;
    logic [NUM_LANES-1:0] lane_n;
    logic [DATA_W-1:0]    rdata_q;

    assign new_xfer = '{addr: req_addr, lanes: req_lanes, wdata: req_wdata};

    sram_req_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .din  (new_xfer),
        .dout (cur_xfer)
    );

    sram_seq_fsm #(
        .RD_CYC  (RD_CYC),
        .WP_CYC  (WP_CYC),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_wr      (req_wr),
        .phase_last  (phase_last),
        .guard_clear (guard_clear),
        .state       (state),
        .accept      (accept),
        .phase_load  (phase_load),
        .phase_val   (phase_val),
        .guard_arm   (guard_arm),
        .capture     (capture)
    );

    sram_phase_ctr #(.W(CNT_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (phase_load),
        .load_val (phase_val),
        .last     (phase_last)
    );

    sram_turn_guard #(.W(CNT_W), .TA_CYC(TA_CYC)) u_guard (
        .clk   (clk),
        .rst   (rst),
        .arm   (guard_arm),
        .clear (guard_clear)
    );

    assign active = (state != ST_IDLE);

    // Per-lane strobe decode and read capture
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_n[g] = !(active && cur_xfer.lanes[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                rdata_q[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata_q[g*LANE_W +: LANE_W] <= cur_xfer.lanes[g]
                                              ? sram_dq_i[g*LANE_W +: LANE_W]
                                              : '0;
            end
        end
    end

    assign ready      = !active;
    assign rdata      = rdata_q;
    assign sram_addr  = cur_xfer.addr;
    assign sram_ce_n  = !active;
    assign sram_oe_n  = (state != ST_READ);
    assign sram_we_n  = (state != ST_WPULSE);
    assign sram_lb_n  = lane_n[0];
    assign sram_ub_n  = lane_n[NUM_LANES-1];
    assign sram_dq_o  = cur_xfer.wdata;
    assign sram_dq_oe = (state == ST_WPULSE) || (state == ST_WREC);

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk
    import sram_lane_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int GRADE_NS = 70
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req,
    input logic                 ready,
    input logic                 ce_n,
    input logic                 oe_n,
    input logic                 we_n,
    input logic [NUM_LANES-1:0] lane_n,
    input logic                 dq_oe,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    dq_o
);

    localparam limits_t LIM = grade_limits(GRADE_NS);
    localparam int WP_CYC = ns_to_cyc(max2(LIM.wp_ns, LIM.ds_ns), CLK_NS);
    localparam int TA_CYC = ns_to_cyc(LIM.ohz_ns, CLK_NS);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] we_lo_cnt;
    logic [CNT_W-1:0] oe_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= SAT;
        end else begin
            if (!we_n) we_lo_cnt <= (we_lo_cnt == SAT) ? SAT : we_lo_cnt + 1'b1;
            else       we_lo_cnt <= '0;
            if (!oe_n) oe_hi_cnt <= '0;
            else if (oe_hi_cnt != SAT) oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (ce_n && oe_n && we_n && (&lane_n) && !dq_oe));

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> !ready);

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(lane_n) && $stable(dq_o)));

    assert_read_pins_R3: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!ce_n && we_n && !dq_oe));

    assert_write_no_oe_R5: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (oe_n && !ce_n));

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_lo_cnt == CNT_W'(WP_CYC)));

    assert_data_driven_R6: assert property (@(posedge clk) disable iff (rst)
        (!we_n || $rose(we_n)) |-> dq_oe);

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> (oe_hi_cnt >= CNT_W'(TA_CYC)));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .CLK_NS   (CLK_NS),
    .GRADE_NS (GRADE_NS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .ready  (ready),
    .ce_n   (sram_ce_n),
    .oe_n   (sram_oe_n),
    .we_n   (sram_we_n),
    .lane_n ({sram_ub_n, sram_lb_n}),
    .dq_oe  (sram_dq_oe),
    .addr   (sram_addr),
    .dq_o   (sram_dq_o)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

    // Expected counts from R8 at a 10 ns clock, 70 ns set
    localparam int EXP_RD = (70 + 9) / 10;
    localparam int EXP_WP = (55 + 9) / 10;
    localparam int EXP_WC = (70 + 9) / 10;
    localparam real T_ACC = 68.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_lanes = '0;
    logic [15:0] req_wdata = '0;
    logic        ready;
    logic [15:0] rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_i;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sram_lane_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_lanes(req_lanes), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] mmem   [int unsigned];
    logic [15:0] shadow [int unsigned];
    real  last_chg = 0.0, we_fall = 0.0, data_chg = 0.0, oe_rise = -1000.0, last_gap = 1000.0;
    bit   we_fell = 0;
    bit   acc_ok = 0;
    logic [15:0] mword;

    function automatic logic [15:0] mread(input int unsigned a);
        return mmem.exists(a) ? mmem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] sread(input int unsigned a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    always @(sram_addr or sram_ce_n or sram_oe_n) last_chg = $realtime;
    always @(sram_dq_o or sram_dq_oe) data_chg = $realtime;
    always @(posedge sram_oe_n) oe_rise = $realtime;
    always @(negedge sram_we_n) begin we_fall = $realtime; we_fell = 1; end

    initial forever begin
        #1;
        acc_ok = ($realtime - last_chg) >= T_ACC;
    end

    always_comb begin
        mword = acc_ok ? mread(int'(sram_addr)) : 16'hDEAD;
        if (!sram_ce_n && !sram_oe_n && sram_we_n)
            sram_dq_i = {sram_ub_n ? 8'h00 : mword[15:8], sram_lb_n ? 8'h00 : mword[7:0]};
        else
            sram_dq_i = 16'h0000;
    end

    always @(posedge sram_we_n) begin
        if (we_fell && !rst) begin
            logic [15:0] w;
            chk(($realtime - we_fall) >= 55.0, "R5 strobe pulse ns", 32'($rtoi($realtime - we_fall)), 32'd55);
            chk(($realtime - data_chg) >= 30.0 && sram_dq_oe, "R6 data setup ns", 32'($rtoi($realtime - data_chg)), 32'd30);
            chk(!sram_ce_n, "R6 ce low at strobe end", 32'(sram_ce_n), 32'd0);
            w = mread(int'(sram_addr));
            if (!sram_lb_n) w[7:0]  = sram_dq_o[7:0];
            if (!sram_ub_n) w[15:8] = sram_dq_o[15:8];
            mmem[int'(sram_addr)] = w;
        end
    end

    always @(posedge sram_dq_oe) begin
        if (!rst) begin
            last_gap = $realtime - oe_rise;
            chk(last_gap >= 25.0 && sram_oe_n, "R7 bus turnaround ns", 32'($rtoi(last_gap)), 32'd25);
        end
    end

    // ---------------- user-side access task ----------------
    task automatic access(input bit wr, input logic [17:0] a, input logic [1:0] ln,
                          input logic [15:0] d, output logic [15:0] rd,
                          output int ce_lo, output int we_lo);
        while (!ready) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_lanes = ln; req_wdata = d;
        @(negedge clk);
        req = 1'b0; req_wdata = ~d; req_addr = ~a;
        chk(!ready, "R2 ready low after accept", 32'(ready), 32'd0);
        ce_lo = 0; we_lo = 0;
        while (!ready) begin
            if (!sram_ce_n) ce_lo++;
            if (!sram_we_n) we_lo++;
            @(negedge clk);
        end
        rd = rdata;
        chk(sram_ce_n && sram_oe_n && sram_we_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
            "R9 standby after access", {27'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n}, 32'h1F);
        if (wr) begin
            logic [15:0] s;
            s = sread(int'(a));
            if (ln[0]) s[7:0]  = d[7:0];
            if (ln[1]) s[15:8] = d[15:8];
            shadow[int'(a)] = s;
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [17:0] a, input logic [1:0] ln);
        logic [15:0] s;
        s = sread(int'(a));
        return {ln[1] ? s[15:8] : 8'h00, ln[0] ? s[7:0] : 8'h00};
    endfunction

    task automatic do_read(input logic [17:0] a, input logic [1:0] ln, input string tag);
        logic [15:0] rd; int ce_lo, we_lo;
        access(1'b0, a, ln, 16'h0, rd, ce_lo, we_lo);
        chk(rd == exp_read(a, ln), tag, 32'(rd), 32'(exp_read(a, ln)));
        chk(ce_lo == EXP_RD && we_lo == 0, "R3 read length", 32'(ce_lo), 32'(EXP_RD));
    endtask

    task automatic do_write(input logic [17:0] a, input logic [1:0] ln, input logic [15:0] d);
        logic [15:0] rd; int ce_lo, we_lo;
        access(1'b1, a, ln, d, rd, ce_lo, we_lo);
        chk(we_lo == EXP_WP, "R5 strobe cycles", 32'(we_lo), 32'(EXP_WP));
        chk(ce_lo >= EXP_WC, "R6 write cycle length", 32'(ce_lo), 32'(EXP_WC));
    endtask

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [17:0] pool [8];

    initial begin
        void'($urandom(32'd2468));
        for (int i = 0; i < 8; i++) pool[i] = 18'((i * 32771 + 4097) & 18'h3FFFF);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset / idle state
        chk(ready && sram_ce_n && sram_oe_n && sram_we_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
            "R1 reset standby", {26'd0, ready, sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n}, 32'h3F);
        chk(rdata == 16'h0, "R4 rdata after reset", 32'(rdata), 32'h0);

        // R5: all four lane masks on one word
        do_write(18'h00123, 2'b11, 16'hFFFF);
        do_write(18'h00123, 2'b00, 16'h1234);
        do_read (18'h00123, 2'b11, "R5 mask 00 writes nothing");
        do_write(18'h00123, 2'b01, 16'hAB56);
        do_read (18'h00123, 2'b11, "R5 lower-only write");
        do_write(18'h00123, 2'b10, 16'h78CD);
        do_read (18'h00123, 2'b11, "R5 upper-only write");
        // R4: disabled lanes read as zero
        do_read (18'h00123, 2'b01, "R4 lower-lane read");
        do_read (18'h00123, 2'b10, "R4 upper-lane read");
        do_read (18'h00123, 2'b00, "R4 no-lane read");
        // R3 and R8: address extremes
        do_write(18'h3FFFF, 2'b11, 16'hC3A5);
        do_write(18'h00000, 2'b11, 16'h5A3C);
        do_read (18'h3FFFF, 2'b11, "R3 top address");
        do_read (18'h00000, 2'b11, "R3 bottom address");
        // R7: write right after read
        do_write(18'h00000, 2'b10, 16'h9900);
        chk(last_gap >= 30.0, "R7 guard after read", 32'($rtoi(last_gap)), 32'd30);
        do_read (18'h00000, 2'b11, "R7 read after turnaround write");

        // Random mix (R2..R7)
        for (int n = 0; n < 400; n++) begin
            logic [17:0] a;
            logic [1:0]  ln;
            a  = pool[$urandom_range(0, 7)];
            ln = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) do_write(a, ln, 16'($urandom));
            else                            do_read(a, ln, "R4 random read");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule